// File: doc/BRIEF.md
# Parallel Cell Histogram Accumulator

This block builds the nine-bin orientation histogram of one 8x8 pixel cell. Each clock cycle it can take one row of eight gradient samples. Every sample carries an orientation bin index, already quantized upstream, and a gradient magnitude. In a single cycle the block adds all eight magnitudes of the row into the bins their indices select. Samples that share a bin are summed together before that bin's total is updated.

A row-valid input qualifies each row, so gaps in the incoming stream cost nothing. When the eighth valid row has been taken, the finished histogram appears on the output bus together with a one-cycle valid strobe. During that strobe cycle the bin registers start the next cell. If a row arrives in that same cycle it becomes the first row of the new cell, so cells can follow one another every eight cycles with no bubble. Angle and magnitude computation, block normalization, classification and storage belong to neighbouring blocks.

Top module: `cell_hist_accum`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the next cycle shows `hist_vld` low and every bin of `hist_bins` equal to zero.
- R2: Each valid row adds the magnitude of every lane into the bin selected by that lane's 4-bit index. Legal index values are 0 to 8, and bin b occupies `hist_bins[b*ACC_W +: ACC_W]`.
- R3: Lanes of one row that carry the same index all add into that bin within the same cycle.
- R4: A lane whose index is 9 to 15 adds nothing to any bin.
- R5: `hist_vld` is high for exactly one cycle. That cycle follows the clock edge that accepted the eighth valid row of a cell. During that cycle `hist_bins` holds the totals of those eight rows.
- R6: A row presented with `row_vld` low changes no bin and does not count toward the eight rows of a cell.
- R7: A valid row accepted while `hist_vld` is high is the first row of the next cell. The next cell's totals never include the previous cell.
- R8: Each bin is `MAG_W`+6 bits wide. All 64 samples of a cell at maximum magnitude in one bin give a total of 64 times the maximum magnitude, with no wrap.
- R9: A reset in the middle of a cell discards the partly accumulated rows and restarts the row count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_vld | input | 1 | Row qualifier |
| row_bin | input | LANES*4 | Bin index per lane, lane l at bits [4l+3:4l] |
| row_mag | input | LANES*MAG_W | Magnitude per lane, lane l at [l*MAG_W +: MAG_W] |
| hist_vld | output | 1 | Histogram valid strobe, one cycle per cell |
| hist_bins | output | 9*ACC_W | Bin totals, bin b at [b*ACC_W +: ACC_W] |

## Verification
A row is taken at the rising edge that sees it. The histogram strobe and its totals are registered, so both appear in the cycle after the eighth valid row's edge and are gone one cycle later. The bench drives rows on falling edges. Its monitor samples one time unit after each rising edge, and the explicit strobe checks are taken on the falling edge right after the final row and on the falling edge after that. The driver queues each cell's expected totals before the cell's rows are driven. The monitor pops one entry per strobe, so a late, early, missing or extra strobe shows up as an order mismatch or as an unexpected strobe.

// File: rtl/chist_pkg.sv
package chist_pkg;
  localparam int NBINS = 9;
  localparam int BIN_W = 4;

  // true when an index selects one of the nine bins
  function automatic logic bin_legal(input logic [BIN_W-1:0] idx);
    return idx < BIN_W'(NBINS);
  endfunction

  // true when index idx selects bin b
  function automatic logic bin_hit(input logic [BIN_W-1:0] idx, input int b);
    return bin_legal(idx) && (idx == BIN_W'(b));
  endfunction
endpackage

// File: rtl/chist_row_fold.sv
module chist_row_fold
  import chist_pkg::*;
#(
  parameter int LANES = 8,
  parameter int MAG_W = 8,
  parameter int ACC_W = 14
) (
  input  logic [LANES-1:0][BIN_W-1:0] lane_idx,
  input  logic [LANES-1:0][MAG_W-1:0] lane_mag,
  output logic [NBINS-1:0][ACC_W-1:0] row_sum,
  output logic [LANES-1:0]            lane_drop
);
  // every lane is compared against every bin; the matching magnitudes are summed per bin
  always_comb begin
    for (int b = 0; b < NBINS; b++) begin
      row_sum[b] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (bin_hit(lane_idx[l], b)) row_sum[b] = row_sum[b] + ACC_W'(lane_mag[l]);
      end
    end
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_drop
      assign lane_drop[l] = !bin_legal(lane_idx[l]);
    end
  endgenerate
endmodule

// File: rtl/chist_row_seq.sv
module chist_row_seq #(
  parameter int ROWS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic row_vld,
  output logic row_last,
  output logic cell_close
);
  localparam int CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [CNT_W-1:0] row_cnt;

  assign row_last = row_vld && (row_cnt == CNT_W'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      row_cnt    <= '0;
      cell_close <= 1'b0;
    end else begin
      cell_close <= row_last;
      if (row_last)     row_cnt <= '0;
      else if (row_vld) row_cnt <= row_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/chist_bin_bank.sv
module chist_bin_bank
  import chist_pkg::*;
#(
  parameter int ACC_W = 14
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        row_vld,
  input  logic                        reload,
  input  logic [NBINS-1:0][ACC_W-1:0] row_sum,
  output logic [NBINS-1:0][ACC_W-1:0] acc
);
  generate
    for (genvar b = 0; b < NBINS; b++) begin : g_bin
      always_ff @(posedge clk) begin
        if (rst)          acc[b] <= '0;
        else if (reload)  acc[b] <= row_vld ? row_sum[b] : '0;
        else if (row_vld) acc[b] <= acc[b] + row_sum[b];
      end
    end
  endgenerate
endmodule

// File: rtl/cell_hist_accum.sv
module cell_hist_accum
  import chist_pkg::*;
#(
  parameter int LANES = 8,
  parameter int ROWS  = 8,
  parameter int MAG_W = 8,
  localparam int ACC_W = MAG_W + $clog2(LANES * ROWS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    row_vld,
  input  logic [LANES*BIN_W-1:0]  row_bin,
  input  logic [LANES*MAG_W-1:0]  row_mag,
  output logic                    hist_vld,
  output logic [NBINS*ACC_W-1:0]  hist_bins
);
  logic [LANES-1:0][BIN_W-1:0] lane_idx;
  logic [LANES-1:0][MAG_W-1:0] lane_mag;
  logic [NBINS-1:0][ACC_W-1:0] row_sum;
  logic [NBINS-1:0][ACC_W-1:0] acc;
  logic [LANES-1:0]            lane_drop;
  logic                        row_last;
  logic                        cell_close;

  assign lane_idx = row_bin;
  assign lane_mag = row_mag;

  chist_row_fold #(.LANES(LANES), .MAG_W(MAG_W), .ACC_W(ACC_W)) i_fold (
    .lane_idx (lane_idx),
    .lane_mag (lane_mag),
    .row_sum  (row_sum),
    .lane_drop(lane_drop)
  );

  chist_row_seq #(.ROWS(ROWS)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .row_vld   (row_vld),
    .row_last  (row_last),
    .cell_close(cell_close)
  );

  chist_bin_bank #(.ACC_W(ACC_W)) i_bank (
    .clk    (clk),
    .rst    (rst),
    .row_vld(row_vld),
    .reload (cell_close),
    .row_sum(row_sum),
    .acc    (acc)
  );

  assign hist_vld  = cell_close;
  assign hist_bins = acc;
endmodule

// File: rtl/cell_hist_accum_chk.sv
module cell_hist_accum_chk
  import chist_pkg::*;
#(
  parameter int LANES = 8,
  parameter int ACC_W = 14
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   row_vld,
  input logic [LANES-1:0]       lane_drop,
  input logic                   row_last,
  input logic                   hist_vld,
  input logic [NBINS*ACC_W-1:0] hist_bins
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!hist_vld && hist_bins == '0)); // R1

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    hist_vld |=> !hist_vld); // R5

  AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    row_last |=> hist_vld); // R5

  AST_DROP_LANES: assert property (@(posedge clk) disable iff (rst)
    (row_vld && (&lane_drop) && !hist_vld) |=> $stable(hist_bins)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!row_vld && !hist_vld) |=> $stable(hist_bins)); // R6

  generate
    for (genvar b = 0; b < NBINS; b++) begin : g_mono
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !hist_vld |=> (hist_bins[b*ACC_W +: ACC_W] >= $past(hist_bins[b*ACC_W +: ACC_W]))); // R8
    end
  endgenerate
endmodule

bind cell_hist_accum cell_hist_accum_chk #(.LANES(LANES), .ACC_W(ACC_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .row_vld  (row_vld),
  .lane_drop(lane_drop),
  .row_last (row_last),
  .hist_vld (hist_vld),
  .hist_bins(hist_bins)
);

// File: tb/test_cell_hist_accum.sv
module test_cell_hist_accum;
  localparam int LANES = 8;
  localparam int ROWS  = 8;
  localparam int MAG_W = 8;
  localparam int NB    = 9;
  localparam int AW    = MAG_W + 6;
  localparam int MAXM  = (1 << MAG_W) - 1;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  row_vld = 1'b0;
  logic [LANES*4-1:0]    row_bin = '0;
  logic [LANES*MAG_W-1:0] row_mag = '0;
  logic                  hist_vld;
  logic [NB*AW-1:0]      hist_bins;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [NB*AW-1:0] exp_q[$];
  string            tag_q[$];

  cell_hist_accum #(.LANES(LANES), .ROWS(ROWS), .MAG_W(MAG_W)) i_cell_hist_accum (
    .clk(clk), .rst(rst), .row_vld(row_vld), .row_bin(row_bin),
    .row_mag(row_mag), .hist_vld(hist_vld), .hist_bins(hist_bins)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [NB*AW-1:0] act, input logic [NB*AW-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: pop one expected histogram per strobe
  always @(posedge clk) begin
    #1;
    cycles++;
    if (!rst && hist_vld) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5 actual=unexpected strobe expected=no strobe");
      end else begin
        check(tag_q.pop_front(), hist_bins, exp_q.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      row_vld = 1'b0;
      row_bin = LANES*4'($urandom);
      row_mag = LANES*MAG_W'($urandom);
      @(negedge clk);
    end
  endtask

  // mode 0 legal random, 1 all lanes bin 3, 2 any index 0..15, 3 max magnitude into bin 8
  // gap: insert an invalid garbage row before each row; push: queue the expected result
  task automatic send_cell(input string tag, input int mode, input bit gap, input bit push, input int nrows);
    int unsigned idx[ROWS][LANES];
    int unsigned mag[ROWS][LANES];
    int unsigned tot[NB];
    logic [NB*AW-1:0] expv;
    for (int b = 0; b < NB; b++) tot[b] = 0;
    for (int r = 0; r < ROWS; r++) begin
      for (int l = 0; l < LANES; l++) begin
        case (mode)
          0: begin idx[r][l] = $urandom % 9;  mag[r][l] = $urandom % (MAXM + 1); end
          1: begin idx[r][l] = 3;             mag[r][l] = $urandom % (MAXM + 1); end
          2: begin idx[r][l] = $urandom % 16; mag[r][l] = $urandom % (MAXM + 1); end
          default: begin idx[r][l] = 8;       mag[r][l] = MAXM; end
        endcase
        if (idx[r][l] < 9) tot[idx[r][l]] += mag[r][l];
      end
    end
    expv = '0;
    for (int b = 0; b < NB; b++) expv[b*AW +: AW] = AW'(tot[b]);
    if (push) begin exp_q.push_back(expv); tag_q.push_back(tag); end
    for (int r = 0; r < nrows; r++) begin
      if (gap) idle(1);
      row_vld = 1'b1;
      for (int l = 0; l < LANES; l++) begin
        row_bin[l*4 +: 4]         = 4'(idx[r][l]);
        row_mag[l*MAG_W +: MAG_W] = MAG_W'(mag[r][l]);
      end
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1", {hist_vld, hist_bins}, '0);
    rst = 1'b0;
    idle(2);

    send_cell("R2", 0, 1'b0, 1'b1, ROWS);
    // R5: strobe in the cycle after the eighth row's edge, then gone
    check("R5", {{(NB*AW){1'b0}}, hist_vld}, 1);
    idle(1);
    check("R5", {{(NB*AW){1'b0}}, hist_vld}, 0);
    idle(3);

    send_cell("R3", 1, 1'b0, 1'b1, ROWS);
    idle(2);
    send_cell("R4", 2, 1'b0, 1'b1, ROWS);
    idle(2);
    send_cell("R6", 0, 1'b1, 1'b1, ROWS);
    idle(2);
    // R7: back-to-back cells, no gap between them
    send_cell("R7", 0, 1'b0, 1'b1, ROWS);
    send_cell("R7", 2, 1'b0, 1'b1, ROWS);
    send_cell("R7", 1, 1'b0, 1'b1, ROWS);
    idle(2);
    send_cell("R8", 3, 1'b0, 1'b1, ROWS);
    idle(2);

    // R9: abort a partial cell with reset
    send_cell("R9", 0, 1'b0, 1'b0, 5);
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    check("R9", {hist_vld, hist_bins}, '0);
    send_cell("R9", 0, 1'b0, 1'b1, ROWS);
    idle(3);

    // R6: invalid rows only, no strobe may appear (monitor flags any)
    idle(20);
    check("R6", {{(NB*AW){1'b0}}, hist_vld}, 0);

    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R5 actual=%0d pending expected=0 pending", exp_q.size());
    end
    finish_run();
  end

  initial begin
    while (cycles < 100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
    finish_run();
  end
endmodule